// File: doc/BRIEF.md
# Address Monitor Wait Unit

This block holds the monitor state that lets one logical processor idle without polling memory. Software first issues an arm request carrying an address. The unit keeps the 64-byte line that holds that address as its watched region and moves to an armed state. Stores made by other agents arrive on a snoop port. Side events also arrive as single-cycle pulses: interrupts, faults, control-register writes that flush translations, and fast system or far calls. While the monitor is armed, any of these moves it to a triggered state.

A wait request that finds the monitor triggered, or idle, retires at once as a no-op. A wait request that finds it armed asserts `sleep`. The unit then holds the core there until a wake condition arrives. It reports that condition with a one-cycle `wake_valid` pulse and a 3-bit cause code. Every completed wait, whether it slept or not, leaves the monitor idle. A new arm request is needed before the next wait can sleep. The armed and triggered states have no output of their own; they show only in whether a wait sleeps.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while the core sleeps. A requester must hold `req_valid`, `req_op`, `req_addr` and `req_priv` steady until the request is taken. The snoop port and the event pulses cannot be stalled; they are sampled on every edge.

Top module: `addr_watch_unit`

## Requirements
- R1: After reset `sleep`, `wake_valid`, `wake_cause` and `priv_fault` are 0 and `req_ready` is 1. The monitor starts idle, so a first wait request does not raise `sleep`.
- R2: A snoop store (`snoop_valid` high) hits when its address bits above bit 5 equal those of the armed address. The low six bits are ignored. A store to any other line has no effect.
- R3: A wait request (`req_op`=1) taken while the monitor is triggered retires as a no-op. `sleep` stays 0, and the monitor returns to idle.
- R4: A wait request taken while the monitor is armed, with no trigger in that cycle, raises `sleep` from the next cycle. `sleep` stays high until a wake condition is sampled.
- R5: A snoop hit sampled while sleeping drops `sleep` and raises `wake_valid` for exactly one cycle on the next edge, with `wake_cause`=0.
- R6: Wake causes are encoded as 0 store hit, 1 interrupt (`irq_evt`), 2 fault or abort (`fault_evt`), 3 control-register write (`ctlreg_evt`), 4 system or far call (`syscall_evt`). `wake_cause` is 0 whenever `wake_valid` is 0.
- R7: A control-register write or system-call pulse after arming and before the wait triggers the monitor. A pulse of either kind while sleeping wakes the core with cause 3 or 4.
- R8: When several wake sources are present in the same cycle, the lowest cause code is reported.
- R9: A request taken with `req_priv` other than 0 raises `priv_fault` for one cycle on the next edge. Such a request changes neither the monitor state nor the watched line.
- R10: After a wake or a no-op wait the monitor is idle. Stores and events in the idle state are ignored, and a following wait retires at once.
- R11: An arm request (`req_op`=0) at privilege 0 always loads a new line and leaves the monitor armed. This holds even when the monitor was armed or triggered before, and even when a trigger arrives in the same cycle. Stores to the old line then have no effect.
- R12: `req_ready` is 0 exactly while `sleep` is 1. Requests presented during that time are not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_op | input | 1 | 0 = arm monitor, 1 = wait |
| req_addr | input | ADDR_W | Address for an arm request |
| req_priv | input | PRIV_W | Privilege level of the requester, 0 = most privileged |
| snoop_valid | input | 1 | Store by another agent observed |
| snoop_addr | input | ADDR_W | Address of the observed store |
| irq_evt | input | 1 | External interrupt pulse |
| fault_evt | input | 1 | Fault or abort pulse |
| ctlreg_evt | input | 1 | Translation-flushing control-register write pulse |
| syscall_evt | input | 1 | Fast system call or far call pulse |
| sleep | output | 1 | Core is parked in the wait state |
| wake_valid | output | 1 | One-cycle wake indication |
| wake_cause | output | 3 | Wake cause code, valid with wake_valid |
| priv_fault | output | 1 | One-cycle fault for an under-privileged request |

## Verification
The hardest situations to reach from the ports are those where the hidden triggered state matters. Examples are a trigger arriving after arming but before the wait, and a trigger landing in the same cycle as the wait or as a re-arm. The stimulus sets these up by issuing an arm request and then pulsing a side event or a snoop store. It then issues a wait and reads the result from whether `sleep` rises. Simultaneous multi-source pulses during sleep cover the cause priority. Stores to the previous line after a re-arm show that the watched line was replaced.

// File: rtl/awu_pkg.sv
package awu_pkg;
  typedef enum logic [1:0] {
    MON_IDLE  = 2'd0,
    MON_ARMED = 2'd1,
    MON_TRIG  = 2'd2,
    MON_SLEEP = 2'd3
  } mon_state_e;

  localparam int CAUSE_W = 3;
  localparam int NUM_SRC = 5;

  localparam logic OP_ARM  = 1'b0;
  localparam logic OP_WAIT = 1'b1;
endpackage

// File: rtl/awu_line_match.sv
module awu_line_match #(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - LINE_BITS;

  logic [TAG_W-1:0] line_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_tag <= '0;
    end else if (load_en) begin
      line_tag <= load_addr[ADDR_W-1:LINE_BITS];
    end
  end

  assign hit = snoop_valid && (snoop_addr[ADDR_W-1:LINE_BITS] == line_tag);
endmodule

// File: rtl/awu_wake_arbiter.sv
module awu_wake_arbiter #(
  parameter int NUM_SRC = 5,
  parameter int CAUSE_W = 3
) (
  input  logic [NUM_SRC-1:0] src,
  output logic               any,
  output logic [CAUSE_W-1:0] cause
);
  // Lowest index wins: scan from the top so lower sources overwrite.
  always_comb begin
    cause = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (src[i]) cause = i[CAUSE_W-1:0];
    end
  end

  assign any = |src;
endmodule

// File: rtl/awu_ctrl.sv
module awu_ctrl
  import awu_pkg::*;
#(
  parameter int PRIV_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_op,
  input  logic [PRIV_W-1:0]  req_priv,
  input  logic               any_evt,
  input  logic [CAUSE_W-1:0] evt_cause,
  output logic               req_ready,
  output logic               load_line,
  output logic               sleep,
  output logic               wake_valid,
  output logic [CAUSE_W-1:0] wake_cause,
  output logic               priv_fault
);
  mon_state_e st, st_nxt;
  logic req_fire, priv_ok, arm_ok, wait_ok, wake_set;

  assign req_ready = (st != MON_SLEEP);
  assign req_fire  = req_valid && req_ready;
  assign priv_ok   = (req_priv == '0);
  assign arm_ok    = req_fire && priv_ok && (req_op == OP_ARM);
  assign wait_ok   = req_fire && priv_ok && (req_op == OP_WAIT);
  assign load_line = arm_ok;

  always_comb begin
    st_nxt   = st;
    wake_set = 1'b0;
    case (st)
      MON_IDLE: begin
        if (arm_ok) st_nxt = MON_ARMED;
      end
      MON_ARMED: begin
        if (arm_ok)       st_nxt = MON_ARMED;
        else if (wait_ok) st_nxt = any_evt ? MON_IDLE : MON_SLEEP;
        else if (any_evt) st_nxt = MON_TRIG;
      end
      MON_TRIG: begin
        if (arm_ok)       st_nxt = MON_ARMED;
        else if (wait_ok) st_nxt = MON_IDLE;
      end
      MON_SLEEP: begin
        if (any_evt) begin
          st_nxt   = MON_IDLE;
          wake_set = 1'b1;
        end
      end
      default: st_nxt = MON_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= MON_IDLE;
      wake_valid <= 1'b0;
      wake_cause <= '0;
      priv_fault <= 1'b0;
    end else begin
      st         <= st_nxt;
      wake_valid <= wake_set;
      wake_cause <= wake_set ? evt_cause : '0;
      priv_fault <= req_fire && !priv_ok;
    end
  end

  assign sleep = (st == MON_SLEEP);
endmodule

// File: rtl/addr_watch_unit.sv
module addr_watch_unit
  import awu_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LINE_BITS = 6,
  parameter int PRIV_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              irq_evt,
  input  logic              fault_evt,
  input  logic              ctlreg_evt,
  input  logic              syscall_evt,
  output logic              sleep,
  output logic              wake_valid,
  output logic [2:0]        wake_cause,
  output logic              priv_fault
);
  logic               load_line, line_hit, any_evt;
  logic [NUM_SRC-1:0] src_vec;
  logic [CAUSE_W-1:0] evt_cause;

  awu_line_match #(.ADDR_W(ADDR_W), .LINE_BITS(LINE_BITS)) u_match (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_line),
    .load_addr   (req_addr),
    .snoop_valid (snoop_valid),
    .snoop_addr  (snoop_addr),
    .hit         (line_hit)
  );

  // Bit position equals cause code.
  assign src_vec = {syscall_evt, ctlreg_evt, fault_evt, irq_evt, line_hit};

  awu_wake_arbiter #(.NUM_SRC(NUM_SRC), .CAUSE_W(CAUSE_W)) u_arb (
    .src   (src_vec),
    .any   (any_evt),
    .cause (evt_cause)
  );

  awu_ctrl #(.PRIV_W(PRIV_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .req_priv   (req_priv),
    .any_evt    (any_evt),
    .evt_cause  (evt_cause),
    .req_ready  (req_ready),
    .load_line  (load_line),
    .sleep      (sleep),
    .wake_valid (wake_valid),
    .wake_cause (wake_cause),
    .priv_fault (priv_fault)
  );
endmodule

// File: rtl/awu_chk.sv
module awu_chk #(
  parameter int ADDR_W = 32,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_op,
  input logic [PRIV_W-1:0] req_priv,
  input logic              snoop_valid,
  input logic              irq_evt,
  input logic              fault_evt,
  input logic              ctlreg_evt,
  input logic              syscall_evt,
  input logic              sleep,
  input logic              wake_valid,
  input logic [2:0]        wake_cause,
  input logic              priv_fault
);
  // R5
  wake_after_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> ($past(sleep) && !sleep));

  // R4
  sleep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !snoop_valid && !irq_evt && !fault_evt && !ctlreg_evt && !syscall_evt) |=> sleep);

  // R6
  cause_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid |-> (wake_cause <= 3'd4));

  // R6
  cause_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_valid |-> (wake_cause == 3'd0));

  // R8
  irq_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && irq_evt && !snoop_valid) |=> (wake_valid && wake_cause == 3'd1));

  // R9
  fault_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_priv != '0) |=> (priv_fault && !sleep));

  // R9
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> $past(req_valid && req_ready && req_priv != '0));

  // R12
  no_accept_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !req_ready);
endmodule

bind addr_watch_unit awu_chk #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_op      (req_op),
  .req_priv    (req_priv),
  .snoop_valid (snoop_valid),
  .irq_evt     (irq_evt),
  .fault_evt   (fault_evt),
  .ctlreg_evt  (ctlreg_evt),
  .syscall_evt (syscall_evt),
  .sleep       (sleep),
  .wake_valid  (wake_valid),
  .wake_cause  (wake_cause),
  .priv_fault  (priv_fault)
);

// File: tb/addr_watch_unit_bench.sv
module addr_watch_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_op = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_priv = '0;
  logic        snoop_valid = 1'b0;
  logic [31:0] snoop_addr = '0;
  logic        irq_evt = 1'b0, fault_evt = 1'b0, ctlreg_evt = 1'b0, syscall_evt = 1'b0;
  logic        sleep, wake_valid, priv_fault;
  logic [2:0]  wake_cause;

  int nchk = 0;
  int nerr = 0;

  always #4 clk = ~clk;

  addr_watch_unit u_addr_watch_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_priv(req_priv),
    .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
    .irq_evt(irq_evt), .fault_evt(fault_evt), .ctlreg_evt(ctlreg_evt),
    .syscall_evt(syscall_evt), .sleep(sleep), .wake_valid(wake_valid),
    .wake_cause(wake_cause), .priv_fault(priv_fault)
  );

  // Behavioural reference: 0 idle, 1 armed, 2 triggered, 3 asleep
  int          m_st = 0;
  logic [25:0] m_line = '0;
  logic        m_wake = 1'b0, m_fault = 1'b0;
  int          m_cause = 0;

  always @(posedge clk) begin : mdl
    bit fire, ok, arm, wt;
    int c;
    if (!rst_n) begin
      m_st <= 0; m_line <= '0; m_wake <= 1'b0; m_cause <= 0; m_fault <= 1'b0;
    end else begin
      fire = req_valid && (m_st != 3);
      ok   = (req_priv == 2'd0);
      arm  = fire && ok && !req_op;
      wt   = fire && ok && req_op;
      c = -1;
      if (snoop_valid && snoop_addr[31:6] == m_line) c = 0;
      else if (irq_evt) c = 1;
      else if (fault_evt) c = 2;
      else if (ctlreg_evt) c = 3;
      else if (syscall_evt) c = 4;
      m_fault <= fire && !ok;
      m_wake  <= 1'b0;
      m_cause <= 0;
      if (arm) begin
        m_line <= req_addr[31:6];
        m_st   <= 1;
      end else begin
        case (m_st)
          1: if (wt) m_st <= (c >= 0) ? 0 : 3; else if (c >= 0) m_st <= 2;
          2: if (wt) m_st <= 0;
          3: if (c >= 0) begin m_st <= 0; m_wake <= 1'b1; m_cause <= c; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 model sleep", int'(sleep), int'(m_st == 3));
      chk("R12 model ready", int'(req_ready), int'(m_st != 3));
      chk("R5 model wake_valid", int'(wake_valid), int'(m_wake));
      chk("R6 model wake_cause", int'(wake_cause), m_cause);
      chk("R9 model priv_fault", int'(priv_fault), int'(m_fault));
    end
  end

  task automatic issue(input logic op, input logic [31:0] a, input logic [1:0] p);
    req_valid = 1'b1; req_op = op; req_addr = a; req_priv = p;
    @(negedge clk);
    req_valid = 1'b0; req_priv = '0;
  endtask

  task automatic store(input logic [31:0] a);
    snoop_valid = 1'b1; snoop_addr = a;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  task automatic evts(input logic i, input logic f, input logic c, input logic s);
    irq_evt = i; fault_evt = f; ctlreg_evt = c; syscall_evt = s;
    @(negedge clk);
    irq_evt = 0; fault_evt = 0; ctlreg_evt = 0; syscall_evt = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nerr++;
    $display("FAIL R12 watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset sleep", int'(sleep), 0);
    chk("R1 reset ready", int'(req_ready), 1);
    chk("R1 reset wake", int'(wake_valid), 0);
    chk("R1 reset fault", int'(priv_fault), 0);
    issue(1'b1, 0, 0);
    chk("R1 wait after reset no sleep", int'(sleep), 0);

    // R2 miss on other line, R4 sleep, R5 hit with low bits differing
    issue(1'b0, 32'h1000, 0);
    store(32'h1040);
    issue(1'b1, 0, 0);
    chk("R4 armed wait sleeps", int'(sleep), 1);
    chk("R12 ready low asleep", int'(req_ready), 0);
    store(32'h103F);
    chk("R5 wake pulse", int'(wake_valid), 1);
    chk("R5 cause store", int'(wake_cause), 0);
    chk("R2 low bits ignored", int'(sleep), 0);
    @(negedge clk);
    chk("R5 pulse one cycle", int'(wake_valid), 0);

    // R10 idle after wake
    store(32'h1000);
    issue(1'b1, 0, 0);
    chk("R10 wait idle after wake", int'(sleep), 0);

    // R3 triggered wait is a no-op, then idle
    issue(1'b0, 32'h2000, 0);
    store(32'h2010);
    issue(1'b1, 0, 0);
    chk("R3 triggered wait no sleep", int'(sleep), 0);
    issue(1'b1, 0, 0);
    chk("R10 second wait idle", int'(sleep), 0);

    // R6 interrupt and fault causes
    issue(1'b0, 32'h2000, 0);
    issue(1'b1, 0, 0);
    evts(1, 0, 0, 0);
    chk("R6 cause irq", int'(wake_cause), 1);
    issue(1'b0, 32'h2000, 0);
    issue(1'b1, 0, 0);
    evts(0, 1, 0, 0);
    chk("R6 cause fault", int'(wake_cause), 2);

    // R7 side events before wait trigger; during sleep wake
    issue(1'b0, 32'h2000, 0);
    evts(0, 0, 1, 0);
    issue(1'b1, 0, 0);
    chk("R7 ctlreg triggers", int'(sleep), 0);
    issue(1'b0, 32'h2000, 0);
    evts(0, 0, 0, 1);
    issue(1'b1, 0, 0);
    chk("R7 syscall triggers", int'(sleep), 0);
    issue(1'b0, 32'h2000, 0);
    issue(1'b1, 0, 0);
    evts(0, 0, 1, 0);
    chk("R7 cause ctlreg", int'(wake_cause), 3);
    issue(1'b0, 32'h2000, 0);
    issue(1'b1, 0, 0);
    evts(0, 0, 0, 1);
    chk("R7 cause syscall", int'(wake_cause), 4);

    // R8 priority
    issue(1'b0, 32'h3000, 0);
    issue(1'b1, 0, 0);
    evts(0, 1, 1, 1);
    chk("R8 fault over lower", int'(wake_cause), 2);
    issue(1'b0, 32'h3000, 0);
    issue(1'b1, 0, 0);
    snoop_valid = 1'b1; snoop_addr = 32'h3008; irq_evt = 1'b1;
    @(negedge clk);
    snoop_valid = 1'b0; irq_evt = 1'b0;
    chk("R8 store over irq", int'(wake_cause), 0);

    // R9 privilege
    issue(1'b0, 32'h4000, 2'd3);
    chk("R9 fault raised", int'(priv_fault), 1);
    issue(1'b1, 0, 0);
    chk("R9 arm ignored", int'(sleep), 0);
    issue(1'b0, 32'h4000, 0);
    issue(1'b1, 0, 2'd1);
    chk("R9 wait faulted", int'(priv_fault), 1);
    chk("R9 wait no sleep", int'(sleep), 0);
    issue(1'b1, 0, 0);
    chk("R9 still armed", int'(sleep), 1);
    evts(1, 0, 0, 0);

    // R11 re-arm replaces line; store in idle ignored
    issue(1'b0, 32'h5000, 0);
    issue(1'b0, 32'h6000, 0);
    store(32'h5000);
    issue(1'b1, 0, 0);
    chk("R11 old line ignored", int'(sleep), 1);
    store(32'h6020);
    chk("R11 new line wakes", int'(wake_valid), 1);
    store(32'h7000);
    issue(1'b0, 32'h7000, 0);
    issue(1'b1, 0, 0);
    chk("R10 idle store ignored", int'(sleep), 1);

    // R12 requests held while asleep are not taken
    req_valid = 1'b1; req_op = 1'b0; req_addr = 32'h8000;
    @(negedge clk);
    chk("R12 not ready", int'(req_ready), 0);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 still asleep", int'(sleep), 1);
    store(32'h7001);
    chk("R12 wake after held req", int'(wake_cause), 0);
    chk("R12 ready again", int'(req_ready), 1);

    // R11 arm wins over same-cycle trigger
    issue(1'b0, 32'h9000, 0);
    req_valid = 1'b1; req_op = 1'b0; req_addr = 32'hA000; irq_evt = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; irq_evt = 1'b0;
    issue(1'b1, 0, 0);
    chk("R11 arm beats trigger", int'(sleep), 1);
    evts(0, 0, 0, 1);

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule